// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire PHY management bus. Software, or a small sequencer, writes 32-bit words into four registers through a simple strobe interface. The block generates the management clock from the system clock and sends the serial frames on the data line. It supports both the short-address frame encoding (Clause 22) and the extended, indirect-address encoding (Clause 45). One bit in the status word selects which encoding is used.

Frames start as a side effect of register writes:

- Writing the data word sends a write frame.
- Writing the address word while the extended encoding is selected sends an address frame.
- Writing the control word with its read bit set sends a read frame.

For a read, the master releases the line for the turnaround and data bits and shifts in the 16 returned bits. It also flags a PHY that never pulls the line low in the second turnaround slot. A busy flag shows that a frame is in flight. Further frame-launching writes are dropped until that frame ends.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads as zero, and both the management clock and the output enable are low.
- R2: Registers are 32-bit words at byte offsets 0x30 (status), 0x34 (control), 0x38 (data) and 0x3C (address). Read data appears one cycle after the read strobe. Status fields are:
  - bit 0: busy
  - bit 1: read error
  - bit 6: extended encoding enable (read/write)
  - bits 15:8: half-divisor (read/write)
- R3: While a frame runs, the management clock toggles every N system clocks, where N is the half-divisor field; a value of 0 acts as 1. The clock rests low when idle.
- R4: Each frame begins with 32 ones unless control bit 10 is set. For a read, bit 10 of the control word that launches the read is the one used.
- R5: In short-address mode, a data write sends the frame 01, 01, port address (control 9:5), register number (control 4:0), 10, then the low 16 data bits, MSB first.
- R6: Writing control with bit 15 set in short-address mode sends 01, 10, port, register, then releases the line for two turnaround bits and 16 data bits. The sampled 16 bits then read back in data bits 15:0.
- R7: With status bit 6 set, an address-register write sends 00, 00, port, device (control 4:0), 10, then the low 16 written bits. With bit 6 clear, the value is only stored and no clock edges occur.
- R8: In extended mode, a data write sends opcode 01 and a read sends opcode 11, both with start bits 00.
- R9: If the line is not low in the second turnaround slot of a read, the read-error bit sets and data reads 0xFFFF. The read-error bit stays set until the next read frame starts.
- R10: Busy reads high in status bit 0 and in data bit 31 from the launching write until the frame's last clock cycle ends.
- R11: While busy, writes to control, data and address are ignored. No frame starts and the stored values do not change.
- R12: The data line and its enable change only on the falling clock edge (or at frame start). The master samples the line on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Byte address of read |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench decodes every frame from the pins and compares each bit and each enable against an expected frame, including the released turnaround and data slots. A wrong opcode, a missing preamble or an early release would show as a mismatched bit.

- A read launched with the preamble-disable bit shows whether the block takes that bit from the launching write; a design that used the stored copy would emit 64 bits.
- A read with no responding PHY must give 0xFFFF, with the error bit surviving later frames until the next read. A design that cleared it on any frame, or that returned the shifted ones without the flag, is caught.
- Writes issued while busy must leave the stored control and data values untouched and start no second frame.
- An address write in short-address mode must produce no clock edges at all.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int unsigned FRAME_BITS = 32;
   localparam int unsigned PRE_BITS   = 32;

   // word indices (byte offset / 4) of the four live registers
   localparam int unsigned WORD_STAT = 12;
   localparam int unsigned WORD_CTRL = 13;
   localparam int unsigned WORD_DATA = 14;
   localparam int unsigned WORD_ADDR = 15;

   // serial frame, first transmitted bit in the MSB
   typedef struct packed {
      logic [1:0]  st;
      logic [1:0]  op;
      logic [4:0]  port;
      logic [4:0]  dev;
      logic [1:0]  ta;
      logic [15:0] data;
   } frame_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half_i,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("mdio_clkgen: DIV_W must lie in 1..8");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] half_eff;
   logic             wrap;

   assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
   assign wrap     = en && (cnt == half_eff - DIV_W'(1));
   assign rise     = wrap && !mdc;
   assign fall     = wrap && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   // R3: an edge event is only ever produced while enabled
   assert_edge_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise || fall) |-> en);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  frame_t      frame_i,
   input  logic        is_read_i,
   input  logic        pre_en_i,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        done,
   output logic [15:0] rd_word,
   output logic        rd_err
);

   localparam int unsigned TOT_BITS = PRE_BITS + FRAME_BITS;
   localparam int unsigned IDX_W    = $clog2(TOT_BITS);
   localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(PRE_BITS);
   localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(TOT_BITS - 1);
   localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(PRE_BITS + 14);
   localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(PRE_BITS + 15);
   localparam logic [IDX_W-1:0] IDX_DAT   = IDX_W'(PRE_BITS + 16);

   if (PRE_BITS != 32 || FRAME_BITS != 32) begin : g_bad_len
      $error("mdio_frame_engine: index arithmetic assumes 32+32 bits");
   end

   logic [31:0]      frame_q;
   logic             is_read_q;
   logic [IDX_W-1:0] idx;
   logic [15:0]      shreg;
   logic             err_q;

   assign done    = busy && fall && (idx == IDX_LAST);
   assign rd_word = shreg;
   assign rd_err  = err_q;
   assign mdio_o  = idx[IDX_W-1] ? frame_q[~idx[4:0]] : 1'b1;
   assign mdio_oe = busy && !(is_read_q && idx >= IDX_TA1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         frame_q   <= '0;
         is_read_q <= 1'b0;
         idx       <= '0;
         shreg     <= '0;
         err_q     <= 1'b0;
      end else if (start) begin
         busy      <= 1'b1;
         frame_q   <= frame_i;
         is_read_q <= is_read_i;
         idx       <= pre_en_i ? '0 : IDX_FIRST;
         shreg     <= '0;
         err_q     <= 1'b0;
      end else if (busy) begin
         if (rise && is_read_q) begin
            if (idx == IDX_TA2) err_q <= mdio_i;
            if (idx >= IDX_DAT) shreg <= {shreg[14:0], mdio_i};
         end
         if (fall) begin
            if (idx == IDX_LAST) busy <= 1'b0;
            else                 idx  <= idx + IDX_W'(1);
         end
      end
   end

   // R11: the register block never launches a frame over a running one
   assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

   // R6: once the line has been released for a read it stays released to the end
   assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mdio_oe && !fall) |=> (!mdio_oe || !busy));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic [15:0]       rd_word_i,
   input  logic              rd_err_i,
   output logic              start_o,
   output frame_t            frame_o,
   output logic              is_read_o,
   output logic              pre_en_o,
   output logic [DIV_W-1:0]  half_o
);

   localparam int unsigned IW = ADDR_W - 2;

   if (ADDR_W < 6) begin : g_bad_aw
      $error("mdio_regs: ADDR_W must reach byte offset 0x3C");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("mdio_regs: DIV_W must lie in 1..8");
   end

   localparam logic [IW-1:0] W_STAT = IW'(WORD_STAT);
   localparam logic [IW-1:0] W_CTRL = IW'(WORD_CTRL);
   localparam logic [IW-1:0] W_DATA = IW'(WORD_DATA);
   localparam logic [IW-1:0] W_ADDR = IW'(WORD_ADDR);

   logic [IW-1:0]    widx, ridx;
   logic             ext_q;
   logic [DIV_W-1:0] div_q;
   logic [4:0]       dev_q, port_q;
   logic             nopre_q;
   logic [15:0]      data_q, addr_q;
   logic             err_q, last_read_q;
   logic             live_wr;
   logic [7:0]       div8;

   assign widx    = wr_addr[ADDR_W-1:2];
   assign ridx    = rd_addr[ADDR_W-1:2];
   assign live_wr = wr_en && !busy_i;
   assign half_o  = div_q;
   assign div8    = 8'(div_q);

   // frame builder: decides whether this write launches a frame and with what
   always_comb begin
      start_o      = 1'b0;
      is_read_o    = 1'b0;
      pre_en_o     = !nopre_q;
      frame_o.st   = ext_q ? 2'b00 : 2'b01;
      frame_o.op   = 2'b01;
      frame_o.port = port_q;
      frame_o.dev  = dev_q;
      frame_o.ta   = 2'b10;
      frame_o.data = wr_data[15:0];
      if (live_wr) begin
         case (widx)
            W_DATA: start_o = 1'b1;
            W_ADDR: if (ext_q) begin
               start_o    = 1'b1;
               frame_o.op = 2'b00;
            end
            W_CTRL: if (wr_data[15]) begin
               start_o      = 1'b1;
               is_read_o    = 1'b1;
               frame_o.op   = ext_q ? 2'b11 : 2'b10;
               frame_o.port = wr_data[9:5];
               frame_o.dev  = wr_data[4:0];
               frame_o.ta   = 2'b11;
               frame_o.data = 16'hFFFF;
               pre_en_o     = !wr_data[10];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q       <= 1'b0;
         div_q       <= '0;
         dev_q       <= '0;
         port_q      <= '0;
         nopre_q     <= 1'b0;
         data_q      <= '0;
         addr_q      <= '0;
         err_q       <= 1'b0;
         last_read_q <= 1'b0;
      end else begin
         if (wr_en && widx == W_STAT) begin
            ext_q <= wr_data[6];
            div_q <= wr_data[8 +: DIV_W];
         end
         if (live_wr && widx == W_CTRL) begin
            dev_q   <= wr_data[4:0];
            port_q  <= wr_data[9:5];
            nopre_q <= wr_data[10];
         end
         if (live_wr && widx == W_DATA) data_q <= wr_data[15:0];
         if (live_wr && widx == W_ADDR) addr_q <= wr_data[15:0];
         if (start_o) begin
            last_read_q <= is_read_o;
            if (is_read_o) err_q <= 1'b0;
         end
         if (done_i && last_read_q) begin
            err_q  <= rd_err_i;
            data_q <= rd_err_i ? 16'hFFFF : rd_word_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         case (ridx)
            W_STAT:  rd_data <= {16'h0, div8, 1'b0, ext_q, 4'h0, err_q, busy_i};
            W_CTRL:  rd_data <= {21'h0, nopre_q, port_q, dev_q};
            W_DATA:  rd_data <= {busy_i, 15'h0, data_q};
            W_ADDR:  rd_data <= {16'h0, addr_q};
            default: rd_data <= '0;
         endcase
      end
   end

   // R9: a finished read that saw no responder leaves all ones in the data word
   assert_err_gives_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_i) && last_read_q && err_q) |-> (data_q == 16'hFFFF));

   // R9: the error flag is clear while a read is running
   assert_err_clear_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && last_read_q && !done_i) |-> !err_q);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   logic             busy, done, start, is_read, pre_en, rd_err, rise, fall;
   logic [15:0]      rd_word;
   logic [DIV_W-1:0] half;
   frame_t           frame;

   mdio_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .busy_i    (busy),
      .done_i    (done),
      .rd_word_i (rd_word),
      .rd_err_i  (rd_err),
      .start_o   (start),
      .frame_o   (frame),
      .is_read_o (is_read),
      .pre_en_o  (pre_en),
      .half_o    (half)
   );

   mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (busy),
      .half_i (half),
      .mdc    (mdc),
      .rise   (rise),
      .fall   (fall)
   );

   mdio_frame_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .frame_i   (frame),
      .is_read_i (is_read),
      .pre_en_i  (pre_en),
      .rise      (rise),
      .fall      (fall),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .done      (done),
      .rd_word   (rd_word),
      .rd_err    (rd_err)
   );

   // R3: the management clock rests low whenever no frame is in flight
   assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R12: line value and enable hold steady across every rising clock edge
   assert_hold_on_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

   localparam int AW = 6;
   localparam logic [AW-1:0] A_STAT = 6'h30, A_CTRL = 6'h34, A_DATA = 6'h38, A_ADDR = 6'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic          mdc, mdio_o, mdio_oe;
   logic          phy_en = 1'b0, phy_v = 1'b1;
   wire           line = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);

   always #5 clk = ~clk;

   mdio_master #(.ADDR_W(AW), .DIV_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line));

   // --- scoreboard item ---
   typedef struct {
      logic [63:0] b;
      logic [63:0] o;
      int          n;
      int          per;
      string       tag;
   } exp_t;
   exp_t q[$];

   int checks = 0, errors = 0, mon_checks = 0, mon_errs = 0;
   int cur_pre = 32;
   bit cur_read = 0, phy_present = 0;
   logic [15:0] phy_data = '0;

   // --- pin monitor and PHY model ---
   int          got_n = 0, base_n = 0;
   logic [63:0] gb = '0, go = '0;
   time         t0 = 0, t1 = 0;
   event        frame_end;

   always @(posedge mdc) begin
      int fi, p;
      fi = got_n - base_n;
      if (fi < 64) begin
         gb[fi] = line;
         go[fi] = mdio_oe;
      end
      if (fi == 0) t0 = $time;
      if (fi == 1) t1 = $time;
      got_n = got_n + 1;
      p = fi + 1 - cur_pre;
      if (cur_read && phy_present && p >= 15 && p <= 31) begin
         phy_en <= 1'b1;
         phy_v  <= (p == 15) ? 1'b0 : phy_data[31-p];
      end else begin
         phy_en <= 1'b0;
      end
   end

   initial begin
      forever begin
         exp_t e;
         int   n;
         bit   ok;
         @(frame_end);
         n = got_n - base_n;
         mon_checks++;
         if (q.size() == 0) begin
            mon_errs++;
            $display("FAIL R5 unexpected frame of %0d bits, expected none", n);
         end else begin
            e  = q.pop_front();
            ok = (n == e.n);
            for (int i = 0; i < 64; i++)
               if (i < e.n && (gb[i] !== e.b[i] || go[i] !== e.o[i])) ok = 0;
            if (!ok) begin
               mon_errs++;
               $display("FAIL %s frame: got n=%0d bits=%h oe=%h, expected n=%0d bits=%h oe=%h",
                        e.tag, n, gb, go, e.n, e.b, e.o);
            end
            mon_checks++;
            if (int'(t1 - t0) != e.per) begin
               mon_errs++;
               $display("FAIL R3 clock period: got %0d ns, expected %0d ns", int'(t1 - t0), e.per);
            end
         end
         base_n = got_n;
         gb = '0;
         go = '0;
      end
   end

   // --- driver side ---
   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      s = 32'h1;
      for (int k = 0; k < 5000 && s[0]; k++) rd(A_STAT, s);
      -> frame_end;
      #1;
   endtask

   // Push the expected line pattern. Bits are indexed in send order.
   task automatic push(string tag, bit pre, logic [1:0] st, logic [1:0] op, logic [4:0] port,
                       logic [4:0] dev, bit rdf, logic [15:0] d, bit phy_ok,
                       logic [15:0] pd, int per);
      exp_t        e;
      logic [31:0] f;
      int          base;
      f    = {st, op, port, dev, (rdf ? 2'b11 : 2'b10), (rdf ? 16'hFFFF : d)};
      e.b  = '1;
      e.o  = '1;
      e.n  = pre ? 64 : 32;
      base = pre ? 32 : 0;
      for (int k = 0; k < 32; k++) begin
         e.b[base+k] = f[31-k];
         if (rdf && k >= 14) begin
            e.o[base+k] = 1'b0;
            if (k == 14)      e.b[base+k] = 1'b1;
            else if (k == 15) e.b[base+k] = !phy_ok;
            else              e.b[base+k] = phy_ok ? pd[31-k] : 1'b1;
         end
      end
      e.per       = per;
      e.tag       = tag;
      cur_pre     = pre ? 32 : 0;
      cur_read    = rdf;
      phy_present = phy_ok;
      phy_data    = pd;
      q.push_back(e);
   endtask

   initial begin
      #1000000;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1,
               errors + mon_errs + 1);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_STAT, v); check(v == 0, "R1", "status after reset", v, 0);
      rd(A_CTRL, v); check(v == 0, "R1", "control after reset", v, 0);
      rd(A_DATA, v); check(v == 0, "R1", "data after reset", v, 0);
      rd(A_ADDR, v); check(v == 0, "R1", "address after reset", v, 0);
      check(mdc == 0 && mdio_oe == 0, "R1", "mdc/oe after reset", {30'b0, mdc, mdio_oe}, 0);

      // R2 status fields read back
      wr(A_STAT, 32'h0000_0200);
      rd(A_STAT, v); check(v == 32'h200, "R2", "status readback", v, 32'h200);

      // R5/R4/R10/R11: short-address write frame with preamble
      wr(A_CTRL, (5 << 5) | 3);
      push("R5", 1, 2'b01, 2'b01, 5'd5, 5'd3, 0, 16'hA5C3, 0, 16'h0, 40);
      wr(A_DATA, 32'h0000_A5C3);
      rd(A_STAT, v); check(v[0] == 1, "R10", "status busy bit", v, 32'h201);
      rd(A_DATA, v); check(v[31] == 1, "R10", "data busy mirror", v, 32'h8000_A5C3);
      wr(A_CTRL, 32'h8000 | (7 << 5) | 1);
      wr(A_DATA, 32'h0000_1111);
      wait_idle();
      rd(A_CTRL, v); check(v == 32'h00A3, "R11", "control kept while busy", v, 32'h00A3);
      rd(A_DATA, v); check(v == 32'h0000_A5C3, "R11", "data kept while busy", v, 32'hA5C3);

      // R6/R4: short-address read, preamble disabled by launching write
      wr(A_STAT, 32'h0000_0300);
      push("R6", 0, 2'b01, 2'b10, 5'd2, 5'd1, 1, 16'h0, 1, 16'h1234, 60);
      wr(A_CTRL, 32'h8000 | 32'h400 | (2 << 5) | 1);
      wait_idle();
      rd(A_DATA, v); check(v == 32'h1234, "R6", "read data", v, 32'h1234);
      rd(A_STAT, v); check(v == 32'h0300, "R6", "no read error", v, 32'h0300);

      // R9: missing responder
      push("R9", 1, 2'b01, 2'b10, 5'd2, 5'd1, 1, 16'h0, 0, 16'h0, 60);
      wr(A_CTRL, 32'h8000 | (2 << 5) | 1);
      wait_idle();
      rd(A_STAT, v); check(v == 32'h0302, "R9", "error flag set", v, 32'h0302);
      rd(A_DATA, v); check(v == 32'hFFFF, "R9", "data all ones", v, 32'hFFFF);

      // R7/R8: extended encoding
      wr(A_STAT, 32'h0000_0140);
      wr(A_CTRL, (9 << 5) | 30);
      push("R7", 1, 2'b00, 2'b00, 5'd9, 5'd30, 0, 16'hBEEF, 0, 16'h0, 20);
      wr(A_ADDR, 32'h0000_BEEF);
      wait_idle();
      rd(A_ADDR, v); check(v == 32'hBEEF, "R7", "address stored", v, 32'hBEEF);
      rd(A_STAT, v); check(v == 32'h0142, "R9", "error persists over address frame", v, 32'h0142);
      push("R8", 1, 2'b00, 2'b01, 5'd9, 5'd30, 0, 16'h0F0F, 0, 16'h0, 20);
      wr(A_DATA, 32'h0000_0F0F);
      wait_idle();
      push("R8", 1, 2'b00, 2'b11, 5'd9, 5'd30, 1, 16'h0, 1, 16'h55AA, 20);
      wr(A_CTRL, 32'h8000 | (9 << 5) | 30);
      wait_idle();
      rd(A_DATA, v); check(v == 32'h55AA, "R8", "extended read data", v, 32'h55AA);
      rd(A_STAT, v); check(v == 32'h0140, "R9", "error cleared by next read", v, 32'h0140);

      // R7: address write in short-address mode starts nothing
      wr(A_STAT, 32'h0000_0100);
      wr(A_ADDR, 32'h0000_4321);
      repeat (50) @(negedge clk);
      check(got_n == base_n && mdc == 0, "R7", "no clock edges", got_n - base_n, 0);
      rd(A_ADDR, v); check(v == 32'h4321, "R7", "address stored only", v, 32'h4321);

      // R3: divisor field of zero behaves as one
      wr(A_STAT, 32'h0000_0000);
      push("R12", 1, 2'b01, 2'b01, 5'd9, 5'd30, 0, 16'h00FF, 0, 16'h0, 20);
      wr(A_DATA, 32'h0000_00FF);
      wait_idle();
      check(q.size() == 0, "R5", "scoreboard drained", q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks,
               errors + mon_errs);
      $finish;
   end

endmodule